// File: doc/BRIEF.md
# Alarm Setting Store with Display Selector

This block keeps the wake-up time of a 12-hour clock and picks which time reaches the display. While the set-alarm input is held high, a small controller watches the hour and minute buttons. Each press adds exactly one step to the stored alarm hours or alarm minutes, however long the button is held. The stored time has no seconds stage, and the minutes never carry into the hours.

The display outputs show the stored alarm time while set-alarm is high, so the user can see the value being adjusted. At all other times they pass the running clock time straight through. The block does not compare the two times and does not drive any ringer.

Hours are an unsigned binary value from 1 to 12, with a separate AM/PM flag (0 = AM, 1 = PM). Minutes are two BCD digits: a tens digit from 0 to 5 and a units digit from 0 to 9.

Top module: `wake_time_store`

## Requirements
- R1: While reset is asserted, and just after it is released, the stored alarm time is 12:00 AM: hours = 12, minute tens = 0, minute units = 0, pm = 0.
- R2: While set_alarm is low, button activity has no effect: the stored alarm time keeps its value.
- R3: With set_alarm high, each press of the hour button alone adds exactly one hour step, whether it is held for one cycle or for several. The step is visible on the outputs after the first rising clock edge at which the press is sampled.
- R4: With set_alarm high, each press of the minute button alone adds exactly one minute step, whether it is held for one cycle or for several.
- R5: Pressing both buttons together changes nothing.
- R6: The minute units digit counts 0 to 9 in BCD. On the step from 9 it returns to 0 and the tens digit advances. The tens digit counts 0 to 5, so the step from 59 gives 00.
- R7: A minutes step, including the wrap from 59 to 00, leaves the alarm hours and pm unchanged.
- R8: Alarm hours step 1, 2, ..., 12 and wrap from 12 to 1.
- R9: The pm flag inverts on the hour step from 11 to 12 and on no other step.
- R10: While set_alarm is high, the display outputs equal the stored alarm time fields.
- R11: While set_alarm is low, the display outputs equal the clock time inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_alarm | input | 1 | High while the alarm time is being adjusted |
| hour_btn | input | 1 | Hour button level |
| min_btn | input | 1 | Minute button level |
| clk_hours | input | 4 | Running clock hours, binary 1..12 |
| clk_min_tens | input | 3 | Running clock minute tens, BCD 0..5 |
| clk_min_ones | input | 4 | Running clock minute units, BCD 0..9 |
| clk_pm | input | 1 | Running clock PM flag |
| alm_hours | output | 4 | Stored alarm hours |
| alm_min_tens | output | 3 | Stored alarm minute tens |
| alm_min_ones | output | 4 | Stored alarm minute units |
| alm_pm | output | 1 | Stored alarm PM flag |
| disp_hours | output | 4 | Selected hours for the display |
| disp_min_tens | output | 3 | Selected minute tens for the display |
| disp_min_ones | output | 4 | Selected minute units for the display |
| disp_pm | output | 1 | Selected PM flag for the display |

## Verification
The hour button is pressed through the full 24-step cycle, with hold lengths rotating from one to four cycles. This shows single-step behaviour for any hold and exposes both the 12-to-1 wrap and the pm inversion at 11-to-12. The minute button is pressed 60 times, which covers every units-to-tens carry and the 59-to-00 wrap, while the bench confirms that the hours do not move. Presses of both buttons at once, and presses with set_alarm low, are applied to check that they are ignored. With set_alarm low, a spread of clock-time values is fed in to separate display pass-through from the alarm path.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int HOUR_W   = 4;
    localparam int TENS_W   = 3;
    localparam int ONES_W   = 4;
    localparam int HOUR_TOP = 12;
    localparam int ONES_MOD = 10;
    localparam int TENS_MOD = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HRS  = 2'd1,
        ST_MINS = 2'd2
    } set_state_e;

    typedef struct packed {
        logic              pm;
        logic [HOUR_W-1:0] hours;
        logic [TENS_W-1:0] tens;
        logic [ONES_W-1:0] ones;
    } wtime_t;
endpackage

// File: rtl/wake_set_fsm.sv
module wake_set_fsm
    import wake_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_alarm,
    input  logic hour_btn,
    input  logic min_btn,
    output logic inc_hr,
    output logic inc_min
);
    set_state_e st_d, st_q;
    logic       hr_only, min_only;

    always_comb begin
        hr_only  = set_alarm && hour_btn && !min_btn;
        min_only = set_alarm && min_btn && !hour_btn;
        st_d     = ST_IDLE;
        inc_hr   = 1'b0;
        inc_min  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (hr_only) begin
                    st_d   = ST_HRS;
                    inc_hr = 1'b1;
                end else if (min_only) begin
                    st_d    = ST_MINS;
                    inc_min = 1'b1;
                end
            end
            ST_HRS:  if (hr_only)  st_d = ST_HRS;
            ST_MINS: if (min_only) st_d = ST_MINS;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wake_hour_ctr.sv
module wake_hour_ctr #(
    parameter int TOP = 12,
    parameter int W   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] hours,
    output logic         pm
);
    localparam logic [W-1:0] LAST   = W'(TOP);
    localparam logic [W-1:0] BEFORE = W'(TOP - 1);
    localparam logic [W-1:0] FIRST  = W'(1);

    typedef struct packed {
        logic         pm;
        logic [W-1:0] hr;
    } hr_state_t;

    hr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (inc) begin
            s_d.hr = (s_q.hr == LAST) ? FIRST : s_q.hr + FIRST;
            if (s_q.hr == BEFORE) s_d.pm = ~s_q.pm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pm: 1'b0, hr: LAST};
        else        s_q <= s_d;
    end

    assign hours = s_q.hr;
    assign pm    = s_q.pm;
endmodule

// File: rtl/wake_min_ctr.sv
module wake_min_ctr #(
    parameter int ONES_MOD = 10,
    parameter int TENS_MOD = 6,
    parameter int OW       = 4,
    parameter int TW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [TW-1:0] tens,
    output logic [OW-1:0] ones
);
    localparam logic [OW-1:0] ONES_LAST = OW'(ONES_MOD - 1);
    localparam logic [TW-1:0] TENS_LAST = TW'(TENS_MOD - 1);

    typedef struct packed {
        logic [TW-1:0] t;
        logic [OW-1:0] o;
    } min_state_t;

    min_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (inc) begin
            if (s_q.o == ONES_LAST) begin
                s_d.o = '0;
                s_d.t = (s_q.t == TENS_LAST) ? '0 : s_q.t + TW'(1);
            end else begin
                s_d.o = s_q.o + OW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tens = s_q.t;
    assign ones = s_q.o;
endmodule

// File: rtl/wake_time_store.sv
module wake_time_store
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_alarm,
    input  logic              hour_btn,
    input  logic              min_btn,
    input  logic [HOUR_W-1:0] clk_hours,
    input  logic [TENS_W-1:0] clk_min_tens,
    input  logic [ONES_W-1:0] clk_min_ones,
    input  logic              clk_pm,
    output logic [HOUR_W-1:0] alm_hours,
    output logic [TENS_W-1:0] alm_min_tens,
    output logic [ONES_W-1:0] alm_min_ones,
    output logic              alm_pm,
    output logic [HOUR_W-1:0] disp_hours,
    output logic [TENS_W-1:0] disp_min_tens,
    output logic [ONES_W-1:0] disp_min_ones,
    output logic              disp_pm
);
    logic   inc_hr, inc_min;
    wtime_t alarm_t, clock_t, shown_t;

    wake_set_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_alarm (set_alarm),
        .hour_btn  (hour_btn),
        .min_btn   (min_btn),
        .inc_hr    (inc_hr),
        .inc_min   (inc_min)
    );

    wake_hour_ctr #(.TOP(HOUR_TOP), .W(HOUR_W)) u_hours (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_hr),
        .hours (alarm_t.hours),
        .pm    (alarm_t.pm)
    );

    wake_min_ctr #(
        .ONES_MOD (ONES_MOD),
        .TENS_MOD (TENS_MOD),
        .OW       (ONES_W),
        .TW       (TENS_W)
    ) u_mins (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_min),
        .tens  (alarm_t.tens),
        .ones  (alarm_t.ones)
    );

    always_comb begin
        clock_t = '{pm: clk_pm, hours: clk_hours, tens: clk_min_tens, ones: clk_min_ones};
        shown_t = set_alarm ? alarm_t : clock_t;
    end

    assign alm_hours     = alarm_t.hours;
    assign alm_min_tens  = alarm_t.tens;
    assign alm_min_ones  = alarm_t.ones;
    assign alm_pm        = alarm_t.pm;
    assign disp_hours    = shown_t.hours;
    assign disp_min_tens = shown_t.tens;
    assign disp_min_ones = shown_t.ones;
    assign disp_pm       = shown_t.pm;
endmodule

// File: rtl/wake_time_store_chk.sv
module wake_time_store_chk
    import wake_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              set_alarm,
    input logic              hour_btn,
    input logic              min_btn,
    input logic [HOUR_W-1:0] clk_hours,
    input logic [TENS_W-1:0] clk_min_tens,
    input logic [ONES_W-1:0] clk_min_ones,
    input logic              clk_pm,
    input logic [HOUR_W-1:0] alm_hours,
    input logic [TENS_W-1:0] alm_min_tens,
    input logic [ONES_W-1:0] alm_min_ones,
    input logic              alm_pm,
    input logic [HOUR_W-1:0] disp_hours,
    input logic [TENS_W-1:0] disp_min_tens,
    input logic [ONES_W-1:0] disp_min_ones,
    input logic              disp_pm
);
    localparam logic [HOUR_W-1:0] H_TOP  = HOUR_W'(HOUR_TOP);
    localparam logic [HOUR_W-1:0] H_PREV = HOUR_W'(HOUR_TOP - 1);
    localparam logic [HOUR_W-1:0] H_ONE  = HOUR_W'(1);
    localparam logic [TENS_W-1:0] T_LAST = TENS_W'(TENS_MOD - 1);
    localparam logic [ONES_W-1:0] O_LAST = ONES_W'(ONES_MOD - 1);

    logic unused_ok;
    assign unused_ok = hour_btn ^ min_btn;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !set_alarm |=> (alm_hours == $past(alm_hours) && alm_pm == $past(alm_pm) &&
                        alm_min_tens == $past(alm_min_tens) && alm_min_ones == $past(alm_min_ones)));

    assert_both_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_btn && min_btn) |=> (alm_hours == $past(alm_hours) &&
                                   alm_min_ones == $past(alm_min_ones)));

    assert_bcd_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_min_tens <= T_LAST && alm_min_ones <= O_LAST));

    assert_min_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(alm_min_ones) || !$stable(alm_min_tens)) |->
            ($stable(alm_hours) && $stable(alm_pm)));

    assert_hour_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alm_hours) |->
            (($past(alm_hours) == H_TOP && alm_hours == H_ONE) ||
             (alm_hours == $past(alm_hours) + H_ONE)));

    assert_pm_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alm_pm) |-> ($past(alm_hours) == H_PREV && alm_hours == H_TOP));

    assert_show_alarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_alarm |-> (disp_hours == alm_hours && disp_pm == alm_pm &&
                       disp_min_tens == alm_min_tens && disp_min_ones == alm_min_ones));

    assert_show_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !set_alarm |-> (disp_hours == clk_hours && disp_pm == clk_pm &&
                        disp_min_tens == clk_min_tens && disp_min_ones == clk_min_ones));
endmodule

bind wake_time_store wake_time_store_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_alarm     (set_alarm),
    .hour_btn      (hour_btn),
    .min_btn       (min_btn),
    .clk_hours     (clk_hours),
    .clk_min_tens  (clk_min_tens),
    .clk_min_ones  (clk_min_ones),
    .clk_pm        (clk_pm),
    .alm_hours     (alm_hours),
    .alm_min_tens  (alm_min_tens),
    .alm_min_ones  (alm_min_ones),
    .alm_pm        (alm_pm),
    .disp_hours    (disp_hours),
    .disp_min_tens (disp_min_tens),
    .disp_min_ones (disp_min_ones),
    .disp_pm       (disp_pm)
);

// File: tb/tb_wake_time_store.sv
module tb_wake_time_store;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_alarm = 1'b0;
    logic       hour_btn = 1'b0;
    logic       min_btn = 1'b0;
    logic [3:0] clk_hours = 4'd1;
    logic [2:0] clk_min_tens = 3'd0;
    logic [3:0] clk_min_ones = 4'd0;
    logic       clk_pm = 1'b0;
    logic [3:0] alm_hours, disp_hours;
    logic [2:0] alm_min_tens, disp_min_tens;
    logic [3:0] alm_min_ones, disp_min_ones;
    logic       alm_pm, disp_pm;

    int n_vec = 0;
    int n_bad = 0;
    int e_hr, e_pm, e_min;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wake_time_store dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_alarm     (set_alarm),
        .hour_btn      (hour_btn),
        .min_btn       (min_btn),
        .clk_hours     (clk_hours),
        .clk_min_tens  (clk_min_tens),
        .clk_min_ones  (clk_min_ones),
        .clk_pm        (clk_pm),
        .alm_hours     (alm_hours),
        .alm_min_tens  (alm_min_tens),
        .alm_min_ones  (alm_min_ones),
        .alm_pm        (alm_pm),
        .disp_hours    (disp_hours),
        .disp_min_tens (disp_min_tens),
        .disp_min_ones (disp_min_ones),
        .disp_pm       (disp_pm)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_alarm(input string req);
        chk({req, " hours"}, alm_hours, e_hr);
        chk({req, " pm"}, alm_pm, e_pm);
        chk({req, " min_tens"}, alm_min_tens, e_min / 10);
        chk({req, " min_ones"}, alm_min_ones, e_min % 10);
    endtask

    task automatic press(input bit hr, input bit mn, input int hold);
        hour_btn = hr;
        min_btn  = mn;
        repeat (hold) @(negedge clk);
        hour_btn = 1'b0;
        min_btn  = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        e_hr = 12; e_pm = 0; e_min = 0;
        repeat (3) @(negedge clk);
        chk_alarm("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_alarm("R1 after release");

        // R2 and R11: buttons with set_alarm low; display follows clock time
        for (int k = 0; k < 12; k++) begin
            clk_hours    = 4'(k + 1);
            clk_min_tens = 3'(k % 6);
            clk_min_ones = 4'((k * 7) % 10);
            clk_pm       = k[0];
            press(k[1], k[2] | ~k[1], 1 + (k % 3));
            chk_alarm("R2 ignored while not setting");
            chk("R11 disp hours", disp_hours, k + 1);
            chk("R11 disp tens", disp_min_tens, k % 6);
            chk("R11 disp ones", disp_min_ones, (k * 7) % 10);
            chk("R11 disp pm", disp_pm, k % 2);
        end

        set_alarm = 1'b1;
        @(negedge clk);
        chk("R10 disp hours", disp_hours, e_hr);

        // R5: both together
        press(1'b1, 1'b1, 3);
        chk_alarm("R5 both pressed");

        // R3, R8, R9: full hour cycle
        for (int k = 0; k < 24; k++) begin
            if (e_hr == 11) e_pm = 1 - e_pm;
            e_hr = (e_hr == 12) ? 1 : e_hr + 1;
            press(1'b1, 1'b0, 1 + (k % 4));
            chk_alarm("R3 R8 R9 hour step");
            chk("R10 disp hours", disp_hours, e_hr);
            chk("R10 disp pm", disp_pm, e_pm);
        end

        // move to 3 PM region so the minute wrap is checked on a nonzero hour
        for (int k = 0; k < 15; k++) begin
            if (e_hr == 11) e_pm = 1 - e_pm;
            e_hr = (e_hr == 12) ? 1 : e_hr + 1;
            press(1'b1, 1'b0, 2);
        end
        chk_alarm("R8 R9 after 15 steps");

        // R4, R6, R7: full minute cycle
        for (int k = 0; k < 60; k++) begin
            e_min = (e_min + 1) % 60;
            press(1'b0, 1'b1, 1 + (k % 4));
            chk_alarm("R4 R6 R7 minute step");
            chk("R10 disp tens", disp_min_tens, e_min / 10);
            chk("R10 disp ones", disp_min_ones, e_min % 10);
        end

        // R2: set_alarm low again, presses ignored, display back to clock
        set_alarm = 1'b0;
        clk_hours = 4'd9; clk_min_tens = 3'd4; clk_min_ones = 4'd2; clk_pm = 1'b1;
        press(1'b1, 1'b0, 2);
        press(1'b0, 1'b1, 2);
        chk_alarm("R2 presses after setting");
        chk("R11 disp hours", disp_hours, 9);
        chk("R11 disp ones", disp_min_ones, 2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule